// File: doc/BRIEF.md
# Store-and-Forward Frame Echo with Address Swap

The block takes in one raw Ethernet frame, a byte per clock, on an 8-bit receive stream. It stores the whole frame in an internal byte buffer, then sends it back out on an 8-bit transmit stream. On the way out, the two 6-byte address fields at the head of the frame trade places. This returns the frame to the station that sent it. Both streams use active-low framing strobes: first byte, last byte, source valid and sink ready.

Reception and transmission never overlap. While the echo is being sent, the receive side reports not-ready. It becomes ready again as soon as the last transmitted byte is accepted. A frame longer than the buffer is cut to the buffer size. A frame too short to hold both address fields is dropped without any output.

Top module: `mac_swap_echo`

## Requirements
- R1: After reset, tx_valid_n, tx_first_n and tx_last_n are 1 and rx_ready_n is 0.
- R2: When idle, capture starts only on a cycle where rx_first_n and rx_valid_n are both 0. That cycle's rx_byte is stored as frame byte 0. Idle cycles with only one of the two low store nothing.
- R3: During capture, a byte is stored and the length is increased only on cycles with rx_valid_n at 0. Cycles with rx_valid_n at 1 add nothing to the frame.
- R4: Capture ends on the cycle with rx_last_n at 0. For a frame that is echoed, tx_valid_n goes to 0 on the next cycle.
- R5: For a stored frame of length L, the transmit byte order is stored bytes 6..11, then 0..5, then 12..L-1.
- R6: tx_first_n is 0 only together with the first transmitted byte. tx_last_n is 0 only together with byte L-1 of the transmit order.
- R7: tx_valid_n stays 0 from the first transmitted byte until the last byte is accepted. On the next cycle it is 1 and the block is idle.
- R8: A byte is accepted only on a cycle with tx_ready_n at 0. While tx_valid_n is 0 and tx_ready_n is 1, tx_byte, tx_first_n and tx_last_n hold their values.
- R9: rx_ready_n is 1 while transmitting and 0 while idle or capturing.
- R10: Bytes past the 1024th byte of a frame are dropped, so at most 1024 bytes are echoed.
- R11: A frame of fewer than 12 stored bytes produces no transmission. A frame of exactly 12 bytes is echoed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_byte | input | 8 | Receive data byte |
| rx_first_n | input | 1 | Receive first-byte strobe, active low |
| rx_last_n | input | 1 | Receive last-byte strobe, active low |
| rx_valid_n | input | 1 | Receive source valid, active low |
| rx_ready_n | output | 1 | Receive sink ready, active low |
| tx_byte | output | 8 | Transmit data byte |
| tx_first_n | output | 1 | Transmit first-byte strobe, active low |
| tx_last_n | output | 1 | Transmit last-byte strobe, active low |
| tx_valid_n | output | 1 | Transmit source valid, active low |
| tx_ready_n | input | 1 | Transmit sink ready, active low |

## Verification
The bench drives stray idle cycles before a frame: a lone valid byte, a lone first-byte strobe, and a lone last-byte strobe. A design that started capture on any of these would shift every echoed byte. Receive gaps and transmit stalls are randomized. A design that stored idle-gap data, or advanced without ready, would emit extra bytes, lose bytes or change a held byte. The length edges are covered by frames of 1, 11, 12, 1024 and 1030 bytes. A wrong runt threshold would drop the 12-byte frame or echo an 11-byte one, and a missing size limit would send more than 1024 bytes.

// File: rtl/mac_swap_echo.sv
module mac_swap_echo #(
  parameter int DW = 8,
  parameter int DEPTH = 1024,
  parameter int ADDR_LEN = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_byte,
  input  logic          rx_first_n,
  input  logic          rx_last_n,
  input  logic          rx_valid_n,
  output logic          rx_ready_n,
  output logic [DW-1:0] tx_byte,
  output logic          tx_first_n,
  output logic          tx_last_n,
  output logic          tx_valid_n,
  input  logic          tx_ready_n
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam int HDR = 2 * ADDR_LEN;

  typedef enum logic [1:0] {S_IDLE, S_CAPT, S_SEND} st_t;

  st_t st;
  logic [DW-1:0] mem [DEPTH];
  logic [CW-1:0] cnt;
  logic [AW-1:0] pos;
  logic [AW-1:0] rd;

  wire idle_start = (st == S_IDLE) && !rx_first_n && !rx_valid_n;
  wire cap_byte   = (st == S_CAPT) && !rx_valid_n;
  wire [CW-1:0] wr_at = idle_start ? '0 : cnt;
  wire wr_en = (idle_start || cap_byte) && (wr_at < CW'(DEPTH));
  wire [CW-1:0] len_next = wr_en ? wr_at + 1'b1 : wr_at;
  wire frame_end = (idle_start || st == S_CAPT) && !rx_last_n;
  wire long_enough = len_next >= CW'(HDR);
  wire at_last = ({1'b0, pos} == cnt - 1'b1);
  wire sending = (st == S_SEND);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= S_IDLE;
      cnt <= '0;
      pos <= '0;
    end else begin
      case (st)
        S_IDLE: if (idle_start) begin
          cnt <= len_next;
          pos <= '0;
          if (frame_end) st <= long_enough ? S_SEND : S_IDLE;
          else           st <= S_CAPT;
        end
        S_CAPT: begin
          cnt <= len_next;
          pos <= '0;
          if (frame_end) st <= long_enough ? S_SEND : S_IDLE;
        end
        S_SEND: if (!tx_ready_n) begin
          if (at_last) st <= S_IDLE;
          else         pos <= pos + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk)
    if (wr_en) mem[wr_at[AW-1:0]] <= rx_byte;

  always_comb begin
    if (pos < AW'(ADDR_LEN))  rd = pos + AW'(ADDR_LEN);
    else if (pos < AW'(HDR))  rd = pos - AW'(ADDR_LEN);
    else                      rd = pos;
  end

  assign tx_byte    = mem[rd];
  assign tx_valid_n = !sending;
  assign tx_first_n = !(sending && pos == '0);
  assign tx_last_n  = !(sending && at_last);
  assign rx_ready_n = sending;

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_n && tx_ready_n) |=> (!tx_valid_n && $stable(tx_byte) &&
      $stable(tx_first_n) && $stable(tx_last_n))); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH)); // R10
  AST_FIRST_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_n && !tx_ready_n) |=> tx_first_n); // R6
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_valid_n && !tx_ready_n && !tx_last_n) |=> (tx_valid_n && !rx_ready_n)); // R7
  AST_RUNT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !long_enough) |=> (tx_valid_n && st == S_IDLE)); // R11
  AST_RX_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && long_enough) |=> (rx_ready_n && !tx_first_n)); // R4
endmodule

// File: tb/test_mac_swap_echo.sv
`timescale 1ns/1ps
module test_mac_swap_echo;
  logic clk = 0, rst_n = 0;
  logic [7:0] rx_byte = 0;
  logic rx_first_n = 1, rx_last_n = 1, rx_valid_n = 1, tx_ready_n = 1;
  logic rx_ready_n, tx_first_n, tx_last_n, tx_valid_n;
  logic [7:0] tx_byte;

  mac_swap_echo i_mac_swap_echo (.clk, .rst_n, .rx_byte, .rx_first_n, .rx_last_n,
    .rx_valid_n, .rx_ready_n, .tx_byte, .tx_first_n, .tx_last_n, .tx_valid_n, .tx_ready_n);

  always #10 clk = ~clk;

  int nchk = 0, nfail = 0, cyc = 0;
  logic [7:0] fr [0:1199];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 190000) begin
      nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 190000);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  function automatic logic [7:0] exp_byte(int k);
    if (k < 6) return fr[k+6];
    if (k < 12) return fr[k-6];
    return fr[k];
  endfunction

  task automatic idle_cycle(input bit v, input bit f, input bit l);
    @(negedge clk);
    rx_valid_n = !v; rx_first_n = !f; rx_last_n = !l; rx_byte = 8'hEE;
    tx_ready_n = 0;
    #1;
    chk(tx_valid_n == 1, "R2 idle", tx_valid_n, 1);
  endtask

  task automatic run_frame(input int n, input int gap, input int stall);
    int idx = 0, got = 0, L, expn, waitc = 0;
    bit pstall = 0, pf = 1, pl = 1, first_post = 1, done = 0;
    logic [7:0] pb = 0;
    L = (n > 1024) ? 1024 : n;
    expn = (L >= 12) ? L : 0;
    while (idx < n) begin
      bit v;
      @(negedge clk);
      v = (idx == 0) ? 1'b1 : (($urandom % 100) >= gap);
      rx_valid_n = !v;
      rx_first_n = !(idx == 0 && v);
      rx_last_n = !(idx == n-1 && v);
      rx_byte = v ? fr[idx] : 8'h5A;
      tx_ready_n = ($urandom % 100) < stall;
      #1;
      chk(rx_ready_n == 0, "R9 capture ready", rx_ready_n, 0);
      chk(tx_valid_n == 1, "R3 no tx in capture", tx_valid_n, 1);
      if (v) idx++;
    end
    while (!done && waitc < 8000) begin
      @(negedge clk);
      rx_valid_n = 1; rx_first_n = 1; rx_last_n = 1; rx_byte = 8'h33;
      tx_ready_n = ($urandom % 100) < stall;
      #1;
      waitc++;
      if (first_post && expn > 0)
        chk(tx_valid_n == 0, "R4 tx starts after eof", tx_valid_n, 0);
      first_post = 0;
      if (expn == 0) begin
        chk(tx_valid_n == 1, "R11 runt silent", tx_valid_n, 1);
        if (waitc >= 30) done = 1;
      end else begin
        chk(tx_valid_n == 0, "R7 valid through tx", tx_valid_n, 0);
        chk(rx_ready_n == 1, "R9 rx blocked in tx", rx_ready_n, 1);
        if (pstall) begin
          chk(tx_byte == pb, "R8 hold byte", tx_byte, pb);
          chk(tx_first_n == pf && tx_last_n == pl, "R8 hold strobes",
              {tx_first_n, tx_last_n}, {pf, pl});
        end
        pstall = tx_ready_n; pb = tx_byte; pf = tx_first_n; pl = tx_last_n;
        if (!tx_ready_n) begin
          chk(tx_byte == exp_byte(got), "R5 order", tx_byte, exp_byte(got));
          chk(tx_first_n == !(got == 0), "R6 first strobe", tx_first_n, !(got == 0));
          chk(tx_last_n == !(got == expn-1), "R6 last strobe", tx_last_n, !(got == expn-1));
          got++;
          if (got >= expn || got >= 1100) done = 1;
        end
      end
    end
    chk(got == expn, "R10 echoed length", got, expn);
    @(negedge clk);
    tx_ready_n = 0;
    #1;
    chk(tx_valid_n == 1, "R7 idle after last", tx_valid_n, 1);
    chk(rx_ready_n == 0, "R9 ready when idle", rx_ready_n, 0);
  endtask

  task automatic fill(input int n);
    for (int k = 0; k < n; k++) fr[k] = 8'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    #1;
    chk(tx_valid_n == 1 && tx_first_n == 1 && tx_last_n == 1, "R1 tx strobes",
        {tx_valid_n, tx_first_n, tx_last_n}, 3'b111);
    chk(rx_ready_n == 0, "R1 rx ready", rx_ready_n, 0);
    @(negedge clk);
    rst_n = 1;

    fill(64);  run_frame(64, 0, 0);
    idle_cycle(1, 0, 0); idle_cycle(0, 1, 0); idle_cycle(0, 0, 1); idle_cycle(1, 0, 1);
    fill(40);  run_frame(40, 0, 0);       // R2: stray idle strobes must not shift data
    fill(80);  run_frame(80, 40, 0);      // R3 receive gaps
    fill(70);  run_frame(70, 0, 50);      // R8 transmit stalls
    fill(12);  run_frame(12, 30, 30);     // R11 exact minimum
    fill(11);  run_frame(11, 20, 20);     // R11 runt
    fill(1);   run_frame(1, 0, 0);        // R11 single byte
    fill(13);  run_frame(13, 0, 0);
    fill(1024); run_frame(1024, 10, 10);  // R10 exact capacity
    fill(1030); run_frame(1030, 10, 10);  // R10 truncation
    for (int t = 0; t < 12; t++) begin
      int n = 12 + ($urandom % 150);
      fill(n);
      run_frame(n, $urandom % 50, $urandom % 50);
    end
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule